// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides a wide unsigned numerator (96 bits by default) by a narrower unsigned denominator (32 bits by default). It returns the full-width quotient and a denominator-width remainder. It works one quotient bit per clock using restoring shift-and-subtract. When a start request is accepted, the block counts the leading zeros of both operands. It shifts the numerator so that its leading one sits one place below the denominator's leading one, and it loads an iteration count equal to the difference in significant bits plus one. Operands that are close in magnitude therefore finish in a few cycles, and only a numerator that is much wider than the denominator takes the full count.

The operands are captured on the clock edge that accepts `start_i`. `busy_o` covers the iterative phase, and a one-cycle `done_o` pulse marks a new result. A denominator with its top bit set produces a partial remainder that can overflow by one bit during a shift. That bit is kept as a headroom bit and forces a subtraction. Two cases complete on the accepting edge itself: a zero denominator and a numerator below the denominator.

Top module: `divr_seq_div`

## Requirements
- R1: For a nonzero denominator d and numerator n, the completed result satisfies n = quo_o*d + rem_o with rem_o < d.
- R2: When n >= d > 0, done_o is high during the cycle after the k-th rising edge that follows the accepting edge. Here k = sigbits(n) - sigbits(d) + 1, and sigbits(x) is the position of x's highest set bit plus one.
- R3: When 0 < d and n < d, done_o is high during the cycle right after the accepting edge, with quo_o = 0 and rem_o = n.
- R4: When d = 0, done_o and div0_o are both high during the cycle right after the accepting edge, with quo_o all ones and rem_o equal to the low DEN_W bits of n. div0_o is never high without done_o.
- R5: done_o and div0_o are high for exactly one cycle per result.
- R6: busy_o is high from the accepting edge of an iterative division until its done edge. A start_i pulse while busy_o is high neither restarts nor alters the running division.
- R7: quo_o and rem_o keep their values from a completion until the next completion.
- R8: Denominators with the top bit set, including all ones, give exact results. The partial remainder always stays below the denominator.
- R9: Changes on num_i and den_i after the accepting edge do not affect the running division.
- R10: After reset, busy_o, done_o and div0_o are 0, and quo_o and rem_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division; accepted only while idle |
| num_i | input | NUM_W | Unsigned numerator, sampled on the accepting edge |
| den_i | input | DEN_W | Unsigned denominator, sampled on the accepting edge |
| busy_o | output | 1 | Iterative division in progress |
| done_o | output | 1 | One-cycle pulse: new result on quo_o/rem_o |
| div0_o | output | 1 | One-cycle pulse with done_o when the denominator was zero |
| quo_o | output | NUM_W | Quotient of the last completed division |
| rem_o | output | DEN_W | Remainder of the last completed division |

## Verification
A wrong alignment shift or iteration count shows up at the ports on the very pulse of done_o. The done edge lands on a cycle other than the one predicted from the operands' significant bits, and the quotient is off by a power of two. A partial remainder that escaped its bound, for example from losing the headroom bit on a top-bit-set denominator, gives a remainder at or above the denominator on that same completion. A corrupt busy/idle state shows as a restarted count, which is observable as a late done_o after a start pulse given mid-run.

// File: rtl/divr_pkg.sv
`timescale 1ns/1ps
package divr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divr_state_e;
endpackage

// File: rtl/divr_lzc.sv
`timescale 1ns/1ps
// Leading-zero counter: returns W when the input is zero.
module divr_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) count_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/divr_align.sv
`timescale 1ns/1ps
// Pre-alignment: places the numerator's leading one just below the
// denominator's leading one inside {partial remainder, quotient bits}
// and derives the number of shift-subtract steps.
module divr_align #(
  parameter int NUM_W = 96,
  parameter int DEN_W = 32,
  localparam int TOT   = NUM_W + DEN_W,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [TOT-1:0]   comb_o,
  output logic [CNT_W-1:0] iter_o
);
  localparam int CWN = $clog2(NUM_W + 1);
  localparam int CWD = $clog2(DEN_W + 1);
  localparam int SW  = $clog2(TOT + 1) + 1;

  logic [CWN-1:0] lz_num;
  logic [CWD-1:0] lz_den;
  logic [SW-1:0]  nsd, dsd, shamt;

  divr_lzc #(.W(NUM_W), .CW(CWN)) lzn_i (.val_i(num_i), .count_o(lz_num));
  divr_lzc #(.W(DEN_W), .CW(CWD)) lzd_i (.val_i(den_i), .count_o(lz_den));

  always_comb begin
    nsd    = SW'(NUM_W) - SW'(lz_num);
    dsd    = SW'(DEN_W) - SW'(lz_den);
    shamt  = SW'(NUM_W) + dsd - SW'(1) - nsd;
    comb_o = TOT'(num_i) << shamt;
    iter_o = CNT_W'(nsd - dsd + SW'(1));
  end
endmodule

// File: rtl/divr_step.sv
`timescale 1ns/1ps
// One restoring step: shift {part, quo} left with the previous quotient
// bit entering at the bottom, then subtract when the shifted partial
// remainder (with its headroom bit) reaches the denominator.
module divr_step #(
  parameter int NUM_W = 96,
  parameter int DEN_W = 32
) (
  input  logic [DEN_W-1:0] part_i,
  input  logic [NUM_W-1:0] quo_i,
  input  logic             qin_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [DEN_W-1:0] part_o,
  output logic [NUM_W-1:0] quo_o,
  output logic             take_o,
  output logic             hr_o
);
  logic [DEN_W-1:0] shifted;

  always_comb begin
    hr_o    = part_i[DEN_W-1];
    shifted = {part_i[DEN_W-2:0], quo_i[NUM_W-1]};
    take_o  = hr_o || (shifted >= den_i);
    part_o  = take_o ? (shifted - den_i) : shifted;
    quo_o   = {quo_i[NUM_W-2:0], qin_i};
  end
endmodule

// File: rtl/divr_seq_div.sv
`timescale 1ns/1ps
module divr_seq_div #(
  parameter int NUM_W = 96,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div0_o,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);
  import divr_pkg::*;

  localparam int TOT   = NUM_W + DEN_W;
  localparam int CNT_W = $clog2(NUM_W + 1);

  divr_state_e      state_q;
  logic [NUM_W-1:0] num_q, qacc_q, quo_q;
  logic [DEN_W-1:0] den_q, part_q, rem_q;
  logic             qbit_q, done_q, div0_q;
  logic [CNT_W-1:0] cnt_q;

  // named internal events
  logic             accept_w, den_zero_w, num_small_w, last_w, headroom_w;
  logic [TOT-1:0]   align_comb;
  logic [CNT_W-1:0] align_iter;
  logic [DEN_W-1:0] step_part;
  logic [NUM_W-1:0] step_quo;
  logic             step_take;

  assign accept_w    = start_i && (state_q == ST_IDLE);
  assign den_zero_w  = (den_i == '0);
  assign num_small_w = (num_i < NUM_W'(den_i));
  assign last_w      = (state_q == ST_RUN) && (cnt_q == CNT_W'(1));

  divr_align #(.NUM_W(NUM_W), .DEN_W(DEN_W)) align_i (
    .num_i  (num_i),
    .den_i  (den_i),
    .comb_o (align_comb),
    .iter_o (align_iter)
  );

  divr_step #(.NUM_W(NUM_W), .DEN_W(DEN_W)) step_i (
    .part_i (part_q),
    .quo_i  (qacc_q),
    .qin_i  (qbit_q),
    .den_i  (den_q),
    .part_o (step_part),
    .quo_o  (step_quo),
    .take_o (step_take),
    .hr_o   (headroom_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      num_q   <= '0;
      den_q   <= '0;
      part_q  <= '0;
      qacc_q  <= '0;
      qbit_q  <= 1'b0;
      cnt_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      div0_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      div0_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            num_q <= num_i;
            den_q <= den_i;
            if (den_zero_w) begin
              done_q <= 1'b1;
              div0_q <= 1'b1;
              quo_q  <= '1;
              rem_q  <= num_i[DEN_W-1:0];
            end else if (num_small_w) begin
              done_q <= 1'b1;
              quo_q  <= '0;
              rem_q  <= num_i[DEN_W-1:0];
            end else begin
              part_q  <= align_comb[TOT-1:NUM_W];
              qacc_q  <= align_comb[NUM_W-1:0];
              qbit_q  <= 1'b0;
              cnt_q   <= align_iter;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (last_w) begin
            quo_q   <= {step_quo[NUM_W-2:0], step_take};
            rem_q   <= step_part;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            part_q <= step_part;
            qacc_q <= step_quo;
            qbit_q <= step_take;
            cnt_q  <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign div0_o = div0_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/divr_seq_div_chk.sv
`timescale 1ns/1ps
module divr_seq_div_chk #(
  parameter int NUM_W = 96,
  parameter int DEN_W = 32,
  localparam int TOT   = NUM_W + DEN_W,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             last,
  input logic             headroom,
  input logic             busy,
  input logic             done,
  input logic             div0,
  input logic [NUM_W-1:0] quo,
  input logic [DEN_W-1:0] rem,
  input logic [NUM_W-1:0] num,
  input logic [DEN_W-1:0] den,
  input logic [DEN_W-1:0] part,
  input logic [CNT_W-1:0] cnt
);
  logic [TOT-1:0] recon;
  assign recon = TOT'(quo) * TOT'(den) + TOT'(rem);

  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div0) |-> (recon == TOT'(num))); // R1
  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div0) |-> (rem < den)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(NUM_W))); // R2
  AST_DIV0_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    div0 |-> (done && den == '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !last) |=> ($stable(quo) && $stable(rem))); // R7
  AST_PART_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (part < den)); // R8
  AST_HEADROOM_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && headroom) |-> den[DEN_W-1]); // R8
  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(den) && $stable(num))); // R9
endmodule

bind divr_seq_div divr_seq_div_chk #(.NUM_W(NUM_W), .DEN_W(DEN_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept_w),
  .last     (last_w),
  .headroom (headroom_w),
  .busy     (busy_o),
  .done     (done_o),
  .div0     (div0_o),
  .quo      (quo_o),
  .rem      (rem_o),
  .num      (num_q),
  .den      (den_q),
  .part     (part_q),
  .cnt      (cnt_q)
);

// File: tb/divr_seq_div_tb_top.sv
`timescale 1ns/1ps
module divr_seq_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // full-width instance
  logic        start_b = 1'b0;
  logic [95:0] num_b = '0;
  logic [31:0] den_b = '0;
  logic        busy_b, done_b, div0_b;
  logic [95:0] quo_b;
  logic [31:0] rem_b;

  // small instance for exhaustive sweep
  logic        start_s = 1'b0;
  logic [7:0]  num_s = '0;
  logic [3:0]  den_s = '0;
  logic        busy_s, done_s, div0_s;
  logic [7:0]  quo_s;
  logic [3:0]  rem_s;

  int checks = 0;
  int errors = 0;

  divr_seq_div dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .num_i(num_b), .den_i(den_b),
    .busy_o(busy_b), .done_o(done_b), .div0_o(div0_b), .quo_o(quo_b), .rem_o(rem_b)
  );

  divr_seq_div #(.NUM_W(8), .DEN_W(4)) small_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_s), .num_i(num_s), .den_i(den_s),
    .busy_o(busy_s), .done_o(done_s), .div0_o(div0_s), .quo_o(quo_s), .rem_o(rem_s)
  );

  task automatic chk(input string tag, input string what,
                     input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic int sigbits(input logic [95:0] v);
    int nb = 0;
    logic [95:0] t = v;
    while (t != 0) begin
      t = t >> 1;
      nb++;
    end
    return nb;
  endfunction

  function automatic logic cur_done(input bit big);
    return big ? done_b : done_s;
  endfunction

  // One division on the chosen instance, checked against arithmetic.
  task automatic run_op(input bit big, input logic [95:0] n, input logic [31:0] d);
    logic [95:0] qe, qg, rw;
    logic [31:0] re, rg;
    logic        zg, ze;
    int          lat_e, extra;
    string       tag;
    if (big) begin
      ze = (d == 0);
      qe = ze ? '1 : n / {64'b0, d};
      rw = ze ? {64'b0, n[31:0]} : n % {64'b0, d};
      re = rw[31:0];
    end else begin
      ze = (d[3:0] == 0);
      qe = ze ? 96'hFF : {88'b0, n[7:0] / {4'b0, d[3:0]}};
      rw = ze ? {92'b0, n[3:0]} : {88'b0, n[7:0] % {4'b0, d[3:0]}};
      re = rw[31:0];
    end
    if (ze) begin
      lat_e = 0; tag = "R4";
    end else if ((big && n < {64'b0, d}) || (!big && n[7:0] < {4'b0, d[3:0]})) begin
      lat_e = 0; tag = "R3";
    end else begin
      lat_e = big ? sigbits(n) - sigbits({64'b0, d})
                  : sigbits({88'b0, n[7:0]}) - sigbits({92'b0, d[3:0]});
      lat_e = lat_e + 1;
      tag = (big ? d[31] : d[3]) ? "R8" : "R1";
    end
    @(negedge clk);
    if (big) begin num_b = n; den_b = d; start_b = 1'b1; end
    else begin num_s = n[7:0]; den_s = d[3:0]; start_s = 1'b1; end
    @(negedge clk);
    start_b = 1'b0;
    start_s = 1'b0;
    extra = 0;
    while (!cur_done(big) && extra < 200) begin
      @(negedge clk);
      extra++;
    end
    qg = big ? quo_b : {88'b0, quo_s};
    rg = big ? rem_b : {28'b0, rem_s};
    zg = big ? div0_b : div0_s;
    chk("R2", "done latency", 96'(extra), 96'(lat_e));
    chk(tag, "quotient", qg, qe);
    chk(tag, "remainder", {64'b0, rg}, {64'b0, re});
    chk("R4", "div0 flag", {95'b0, zg}, {95'b0, ze});
    @(negedge clk);
    chk("R5", "done pulse width", {95'b0, cur_done(big)}, 96'd0);
    chk("R5", "div0 pulse width", {95'b0, (big ? div0_b : div0_s)}, 96'd0);
  endtask

  initial begin
    int edges;
    logic [95:0] ones = '1;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", {95'b0, busy_b}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy after reset", {94'b0, busy_b, busy_s}, 96'd0);
    chk("R10", "done after reset", {94'b0, done_b, done_s}, 96'd0);
    chk("R10", "div0 after reset", {94'b0, div0_b, div0_s}, 96'd0);
    chk("R10", "quotient after reset", quo_b, 96'd0);
    chk("R10", "remainder after reset", {64'b0, rem_b}, 96'd0);

    // Exhaustive sweep of the small configuration (R1..R5, R8)
    for (int n = 0; n < 256; n++) begin
      for (int d = 0; d < 16; d++) begin
        run_op(1'b0, 96'(n), 32'(d));
      end
    end

    // Directed full-width cases
    run_op(1'b1, ones, 32'd1);                                  // R2: longest run
    run_op(1'b1, ones, 32'hFFFF_FFFF);                          // R8
    run_op(1'b1, 96'h8000_0000_0000_0000_0000_0000, 32'h8000_0001); // R8
    run_op(1'b1, 96'h1234_5678_9ABC_DEF0_1234_5678, 32'h0000_1234); // R1
    run_op(1'b1, 96'h0000_0000_0000_0000_FFFF_FFFE, 32'hFFFF_FFFF); // R3
    run_op(1'b1, 96'd5, 32'd7);                                 // R3
    run_op(1'b1, 96'hDEAD_BEEF_0000_0000_CAFE_F00D, 32'd0);     // R4
    run_op(1'b1, 96'hFFFF_FFFF, 32'hFFFF_FFFF);                 // R8, single step
    run_op(1'b1, 96'h0000_0001_0000_0000_0000_0000, 32'h0000_0003); // R1

    // R6/R9: start pulse and operand changes during a long run
    @(negedge clk);
    num_b = ones; den_b = 32'd3; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0; num_b = 96'd5; den_b = 32'd1;
    edges = 0;
    while (!done_b && edges < 200) begin
      @(negedge clk);
      edges++;
      start_b = (edges == 4);
      if (edges == 5) chk("R6", "busy kept after start pulse", {95'b0, busy_b}, 96'd1);
    end
    start_b = 1'b0;
    chk("R6", "latency not restarted", 96'(edges), 96'd95);
    chk("R9", "quotient from captured operands", quo_b, ones / 96'd3);
    chk("R9", "remainder from captured operands", {64'b0, rem_b}, 96'd0);

    // R7: results held with no new start
    num_b = 96'd77; den_b = 32'd9;
    repeat (8) @(negedge clk);
    chk("R7", "quotient held", quo_b, ones / 96'd3);
    chk("R7", "remainder held", {64'b0, rem_b}, 96'd0);
    chk("R7", "no spurious done", {95'b0, done_b}, 96'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule